// File: doc/BRIEF.md
# Serially Controlled Clock Fan-Out Gate

This block copies one reference clock onto ten outputs. Each output has its own enable bit, and a write-only I2C target sets those bits. The bus pins are sampled with a faster system clock. The target answers one parameterized 7-bit address and accepts write transfers only. Data bytes fill three 8-bit control registers in a fixed order, always starting from the first register.

A cleared enable bit holds its output at logic low. A set bit lets the reference clock through. The block never changes an enable on the output side while the reference clock is high, so a write cannot chop a clock pulse short. A separate active-high enable input drives a per-output pad enable vector. When that input is low, the whole vector is low and the pad cells put every output in high impedance. The register contents are left as they are.

Top module: `i2c_clk_fanout`

## Requirements
- R1: After reset, all 24 control bits are 1. With `oe_i` high, `clk_o` equals the reference clock on all ten bits and `clk_oe_o` is all ones.
- R2: The target acknowledges the first byte after a START only when its upper 7 bits equal `DEV_ADDR` and bit 0 (R/W) is 0. It acknowledges by enabling the SDA pull-down (`sda_oe_o`) during the ninth SCL pulse. For any other address, or when R/W is 1, SDA stays released and no register changes.
- R3: Every data byte in an acknowledged write transfer is acknowledged on its ninth SCL pulse.
- R4: The data bytes of a transfer load register 0, then register 1, then register 2. Bytes after the third are acknowledged and discarded. Bit i of register k enables output 8k+i. Register 1 bits 2 to 7 and all of register 2 are stored but drive no output.
- R5: A STOP or a new START (including a repeated START) resets the register pointer, so the next data byte loads register 0 again.
- R6: Each `clk_o[n]` is `ref_clk_i` AND its applied enable bit. An output whose bit is 0 stays low.
- R7: A new enable value is applied only while `ref_clk_i` is low. If a write lands while `ref_clk_i` is high, the outputs keep their old gating until `ref_clk_i` has been low for a system-clock edge.
- R8: `oe_i` low drives `clk_oe_o` to all zeros and `oe_i` high drives it to all ones. The level of `oe_i` has no effect on the register contents or on I2C acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| oe_i | input | 1 | Global output enable, high = drive |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| clk_o | output | 10 | Gated clock outputs |
| clk_oe_o | output | 10 | Per-output pad drive enables |

## Verification
Two functions can fall in the same cycle: a register commit from the I2C side and a high phase of the reference clock. The bench holds `ref_clk_i` high across a complete write transfer, so the commit lands in the middle of a high phase. It first checks that the outputs still show the old gating. It then lowers and raises the reference clock and checks that the new gating appears. Random transfers mix address mismatches, read requests and byte counts from one to five, and a bench model predicts both the acknowledgements and the gating.

// File: rtl/i2c_fanout_pkg.sv
package i2c_fanout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_fanout_sync.sv
module i2c_fanout_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_fanout_target.sv
module i2c_fanout_target
  import i2c_fanout_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       wr_o,
  output logic [7:0] data_o,
  output logic       frame_rst_o,
  output logic       sda_oe_o
);
  tgt_state_e state_q;
  logic [3:0] bit_q;
  logic [7:0] shift_q;
  logic       ack_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      ack_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        ack_q   <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i) begin
              shift_q <= {shift_q[6:0], sda_i};
              bit_q   <= bit_q + 4'd1;
            end else if (scl_fall_i && bit_q == 4'd8) begin
              if (state_q == ST_DATA) begin
                wr_q    <= 1'b1;
                ack_q   <= 1'b1;
                state_q <= ST_DATA_ACK;
              end else if (shift_q[7:1] == DEV_ADDR && !shift_q[0]) begin
                ack_q   <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall_i) begin
              ack_q   <= 1'b0;
              bit_q   <= '0;
              state_q <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_o        = wr_q;
  assign data_o      = shift_q;
  assign frame_rst_o = start_i | stop_i;
  assign sda_oe_o    = ack_q;

  AST_ACK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(scl_fall_i)); // R2
  AST_NO_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !ack_q); // R2
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q); // R3
endmodule

// File: rtl/i2c_fanout_regs.sv
module i2c_fanout_regs #(
  parameter int NUM_REG = 3,
  parameter int REG_W   = 8,
  localparam int PTR_W  = $clog2(NUM_REG + 1),
  localparam int BITS   = NUM_REG * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] data_i,
  input  logic             clr_i,
  output logic [BITS-1:0]  bits_o
);
  logic [REG_W-1:0] regs_q [NUM_REG];
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else if (wr_i && ptr_q != PTR_W'(NUM_REG)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[k] <= '1;
      else if (wr_i && !clr_i && ptr_q == PTR_W'(k)) regs_q[k] <= data_i;
    end
    assign bits_o[k*REG_W +: REG_W] = regs_q[k];
  end

  AST_SEQ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && ptr_q == '0) |=> regs_q[0] == $past(data_i)); // R4
  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(NUM_REG)); // R4
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == '0); // R5
endmodule

// File: rtl/i2c_fanout_gate.sv
module i2c_fanout_gate #(
  parameter int NUM_OUT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  logic [NUM_OUT-1:0] en_q;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    // hold the applied enable through the high phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         en_q[n] <= 1'b1;
      else if (!ref_clk_i) en_q[n] <= en_i[n];
    end
    assign clk_o[n]    = ref_clk_i & en_q[n];
    assign clk_oe_o[n] = oe_i;
  end

  AST_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_clk_i && $past(ref_clk_i)) |-> $stable(en_q)); // R7
endmodule

// File: rtl/i2c_clk_fanout.sv
module i2c_clk_fanout #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_OUT = 10,
  parameter int NUM_REG = 3,
  parameter int REG_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  localparam int BITS = NUM_REG * REG_W;

  logic             sda_s, scl_rise, scl_fall, start, stop;
  logic             wr, frame_rst;
  logic [REG_W-1:0] wdata;
  logic [BITS-1:0]  ctrl_bits;

  i2c_fanout_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_fanout_target #(.DEV_ADDR(DEV_ADDR)) u_tgt (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .wr_o(wr), .data_o(wdata), .frame_rst_o(frame_rst), .sda_oe_o
  );

  i2c_fanout_regs #(.NUM_REG(NUM_REG), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .data_i(wdata), .clr_i(frame_rst),
    .bits_o(ctrl_bits)
  );

  i2c_fanout_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk_i, .rst_ni, .ref_clk_i, .oe_i, .en_i(ctrl_bits[NUM_OUT-1:0]),
    .clk_o, .clk_oe_o
  );

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (clk_oe_o == '0)); // R8
endmodule

// File: tb/i2c_clk_fanout_tb.sv
module i2c_clk_fanout_tb;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 10;

  logic clk = 0, rst_n = 0, ref_m = 0, oe_m = 1, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [9:0] clk_out, clk_oe;
  wire sda_bus = sda_m & ~sda_oe;
  logic [23:0] exp_q = '1;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_clk_fanout u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_m), .oe_i(oe_m),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .clk_o(clk_out), .clk_oe_o(clk_oe)
  );

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1; wc(Q); scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; wc(Q); scl_m = 1; wc(Q); sda_m = 1; wc(Q);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q); scl_m = 1; wc(Q); scl_m = 0;
    end
    sda_m = 1; wc(Q); scl_m = 1; wc(Q/2); ack = ~sda_bus; wc(Q/2); scl_m = 0; wc(2);
  endtask

  function automatic logic [23:0] model_put(input logic [23:0] m, input int idx,
                                            input logic [7:0] b);
    logic [23:0] r = m;
    if (idx < 3) r[idx*8 +: 8] = b;
    return r;
  endfunction

  task automatic xfer(input logic [6:0] a, input logic rw, input int n,
                      input logic [7:0] d [8], input string req);
    logic ack;
    logic match = (a == ADDR) && !rw;
    i2c_start;
    i2c_byte({a, rw}, ack);
    chk({req, " R2 addr ack"}, ack, match);
    if (match) begin
      for (int i = 0; i < n; i++) begin
        i2c_byte(d[i], ack);
        chk(i < 3 ? {req, " R3 data ack"} : {req, " R4 extra ack"}, ack, 1);
        exp_q = model_put(exp_q, i, d[i]);
      end
    end
    i2c_stop;
  endtask

  task automatic chk_out(input string req);
    ref_m = 0; wc(3);
    chk({req, " R6 low"}, clk_out, 0);
    ref_m = 1; wc(1);
    chk({req, " R6 gate"}, clk_out, exp_q[9:0]);
    chk({req, " R8 oe"}, clk_oe, {10{oe_m}});
    ref_m = 0; wc(1);
  endtask

  initial begin
    logic [7:0] d [8];
    logic ack;
    void'($urandom(32'h5eed));
    wc(3); rst_n = 1; wc(3);
    // R1 reset state
    ref_m = 1; wc(1);
    chk("R1 out", clk_out, 10'h3ff);
    chk("R1 oe", clk_oe, 10'h3ff);
    ref_m = 0; wc(1);
    // R4 ordered load, fourth/fifth discarded
    d[0] = 8'hA5; d[1] = 8'h02; d[2] = 8'h77; d[3] = 8'hFF; d[4] = 8'hFF;
    xfer(ADDR, 0, 5, d, "R4 seq");
    chk_out("R4 seq");
    // R2 mismatch and read request
    d[0] = 8'h00; d[1] = 8'h00;
    xfer(ADDR ^ 7'h01, 0, 2, d, "R2 miss");
    chk_out("R2 miss");
    xfer(ADDR, 1, 2, d, "R2 read");
    chk_out("R2 read");
    // R5 repeated start resets pointer
    i2c_start; i2c_byte({ADDR, 1'b0}, ack); chk("R5 addr", ack, 1);
    i2c_byte(8'h3C, ack); i2c_byte(8'h01, ack);
    i2c_start; i2c_byte({ADDR, 1'b0}, ack); chk("R5 readdr", ack, 1);
    i2c_byte(8'hC3, ack); i2c_stop;
    exp_q[15:0] = {8'h01, 8'hC3};
    chk_out("R5 rstart");
    // R7 write lands while reference clock high
    ref_m = 1; wc(2);
    i2c_start; i2c_byte({ADDR, 1'b0}, ack); i2c_byte(8'h0F, ack); i2c_stop;
    wc(4);
    chk("R7 held", clk_out, exp_q[9:0]);
    exp_q[7:0] = 8'h0F;
    ref_m = 0; wc(2); ref_m = 1; wc(1);
    chk("R7 applied", clk_out, exp_q[9:0]);
    ref_m = 0; wc(1);
    // R8 oe low: pads off, registers still written and acked
    oe_m = 0; wc(1);
    chk("R8 off", clk_oe, 0);
    d[0] = 8'h81; d[1] = 8'h03;
    xfer(ADDR, 0, 2, d, "R8 write");
    oe_m = 1; wc(1);
    chk_out("R8 back");
    // random transfers
    for (int t = 0; t < 16; t++) begin
      logic [6:0] a = ADDR;
      logic rw = ($urandom % 5) == 0;
      int n = 1 + $urandom % 5;
      if ($urandom % 4 == 0) a = ADDR ^ 7'(1 + $urandom % 127);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      xfer(a, rw, n, d, "rnd");
      chk_out("rnd");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule